// File: doc/BRIEF.md
# Three-Channel Multimode Timer Bank

The block holds a set of independent timers (three by default). Each one owns a single bidirectional pin, shown at the ports as an input, an output and an output enable, and a set of registers. The timer runs in one of three modes. In pulse generation mode it drives a repeating waveform. In capture mode it measures the high time and the rise-to-rise time of an incoming signal. In event mode it counts edges on its pin and acts as a watchdog. One shared control register turns each timer on or off. The same register holds a sticky event flag per timer.

Software reaches every register over a simple word-wide bus. Writes are strobed and take effect on the next clock edge. Reads are combinational from the address. Each timer raises its interrupt line when its event flag is set and its interrupt enable is on. A debug halt input can freeze any timer whose configuration does not allow it to keep counting during debug.

Top module: `gpt_bank`

## Requirements
- R1: After reset, every register reads zero, no pin is driven (pin_oe low), every pin_out is low and every irq is low.
- R2: Timer i has its registers at word address 4*i: offset 0 is configuration (6 bits, upper bits read as zero), offset 1 is count, offset 2 is period and offset 3 is width. Values written there read back unchanged.
- R3: The control register sits at address 12. Bits [2:0] are the enables of timers 0..2, and each bit is set or cleared by the value written to it. Bits [10:8] read back the event flags of timers 0..2.
- R4: Configuration bits [1:0] select the mode: 01 is pulse generation, 10 is capture, 11 is edge count, and 00 is idle. In pulse generation with enable set, pin_oe is high and the pin is active for `width` clocks out of every `period` clocks.
- R5: In pulse generation, when the count reaches period-1 the count returns to 0 and the timer's event flag is set.
- R6: In capture mode the pin is an input (pin_oe low). The first rising edge after enabling only arms the timer. On every later rising edge, the high time of the last pulse is stored in width, the clocks since the previous rising edge are stored in period, and the event flag is set.
- R7: In edge count mode the pin is an input. The count increases on each rising edge. When it would reach `period`, the count returns to 0 and the event flag is set.
- R8: Configuration bit 2 inverts the pin. The output level is inverted, and the idle level is high while the timer is disabled. Edges are detected on the inverted input.
- R9: Event flags stay set until software writes 1 to the flag's bit in the control register. irq[i] equals flag i AND configuration bit 3 of timer i.
- R10: When configuration bit 5 is 0, an event also clears the timer's enable bit (one-shot). When bit 5 is 1, the timer keeps running.
- R11: A disabled timer does not count and keeps its count, period and width values.
- R12: While dbg_halt is high, a timer whose configuration bit 4 is 0 holds its count. A timer with bit 4 set keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_halt | input | 1 | Debug halt request |
| bus_addr | input | 4 | Word address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | 3 | Level sensed on each timer pin |
| pin_out | output | 3 | Level driven on each timer pin |
| pin_oe | output | 3 | Drive enable of each timer pin |
| irq | output | 3 | Interrupt line per timer |

## Verification
The bench measures the generated waveform over two full periods, so a width or period that is off by one clock changes the high-level count. In capture mode it sends pulses of known high and low length. A design that latched on the arming edge, or counted from the wrong edge, would report a wrong width or period. The bench contrasts the one-shot and free-running settings, and a halted timer with one allowed to run under debug. It also checks that the event flag survives writes of 0 and clears on a write of 1. A design that merged these controls would show the wrong enable bit, flag bit or count.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_PWM  = 2'b01,
        MODE_CAP  = 2'b10,
        MODE_EDGE = 2'b11
    } gpt_mode_e;

    // 6-bit configuration word: [5] run_on, [4] emu_run, [3] irq_en, [2] invert, [1:0] mode
    typedef struct packed {
        logic      run_on;
        logic      emu_run;
        logic      irq_en;
        logic      invert;
        gpt_mode_e mode;
    } gpt_cfg_t;

    localparam int CFG_W = $bits(gpt_cfg_t);

endpackage

// File: rtl/gpt_pin_sync.sv
module gpt_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr_d, sr_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sr_d = d;
        end else begin : g_many
            always_comb sr_d = {sr_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign q = sr_q[STAGES-1];
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
    import gpt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             halt,
    input  logic             pin_i,
    input  logic             cfg_we,
    input  logic             cnt_we,
    input  logic             per_we,
    input  logic             wid_we,
    input  logic [CNT_W-1:0] wdata,
    output gpt_cfg_t         cfg_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_o,
    output logic [CNT_W-1:0] wid_o,
    output logic             pin_o,
    output logic             pin_oe_o,
    output logic             evt_o
);
    localparam logic [CNT_W:0] ONE_X = (CNT_W+1)'(1);

    typedef struct packed {
        gpt_cfg_t         cfg;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] wid;
        logic [CNT_W-1:0] hi;
        logic             lvl_prev;
        logic             armed;
    } chan_t;

    chan_t s_d, s_q;
    logic  pin_s, lvl, rise, fall, active, evt_d;
    logic [CNT_W:0] cnt_nx;

    gpt_pin_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_i),
        .q    (pin_s)
    );

    always_comb begin
        s_d    = s_q;
        evt_d  = 1'b0;
        lvl    = pin_s ^ s_q.cfg.invert;
        rise   = lvl & ~s_q.lvl_prev;
        fall   = ~lvl & s_q.lvl_prev;
        active = en & ~(halt & ~s_q.cfg.emu_run);
        cnt_nx = {1'b0, s_q.cnt} + ONE_X;

        s_d.lvl_prev = lvl;

        // software writes; hardware updates below take priority
        if (cfg_we) s_d.cfg = gpt_cfg_t'(wdata[CFG_W-1:0]);
        if (cnt_we) s_d.cnt = wdata;
        if (per_we) s_d.per = wdata;
        if (wid_we) s_d.wid = wdata;

        if (!en) s_d.armed = 1'b0;

        if (active) begin
            unique case (s_q.cfg.mode)
                MODE_PWM: begin
                    if (cnt_nx >= {1'b0, s_q.per}) begin
                        s_d.cnt = '0;
                        evt_d   = 1'b1;
                    end else begin
                        s_d.cnt = cnt_nx[CNT_W-1:0];
                    end
                end
                MODE_CAP: begin
                    s_d.cnt = cnt_nx[CNT_W-1:0];
                    if (fall) s_d.hi = cnt_nx[CNT_W-1:0];
                    if (rise) begin
                        s_d.cnt   = '0;
                        s_d.armed = 1'b1;
                        if (s_q.armed) begin
                            s_d.wid = s_q.hi;
                            s_d.per = cnt_nx[CNT_W-1:0];
                            evt_d   = 1'b1;
                        end
                    end
                end
                MODE_EDGE: begin
                    if (rise) begin
                        if (cnt_nx >= {1'b0, s_q.per}) begin
                            s_d.cnt = '0;
                            evt_d   = 1'b1;
                        end else begin
                            s_d.cnt = cnt_nx[CNT_W-1:0];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign evt_o    = evt_d;
    assign cfg_o    = s_q.cfg;
    assign cnt_o    = s_q.cnt;
    assign per_o    = s_q.per;
    assign wid_o    = s_q.wid;
    assign pin_oe_o = en & (s_q.cfg.mode == MODE_PWM);
    assign pin_o    = pin_oe_o ? ((s_q.cnt < s_q.wid) ^ s_q.cfg.invert) : s_q.cfg.invert;
endmodule

// File: rtl/gpt_bank.sv
module gpt_bank
    import gpt_pkg::*;
#(
    parameter int N_TMR     = 3,
    parameter int CNT_W     = 32,
    parameter int STS_LSB   = 8,
    parameter int SYNC_STGS = 2,
    localparam int ADDR_W   = $clog2(4*N_TMR+1),
    localparam int SEL_W    = ADDR_W-2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_halt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [N_TMR-1:0]  pin_in,
    output logic [N_TMR-1:0]  pin_out,
    output logic [N_TMR-1:0]  pin_oe,
    output logic [N_TMR-1:0]  irq
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(4*N_TMR);

    typedef struct packed {
        logic [N_TMR-1:0] en;
        logic [N_TMR-1:0] sts;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    gpt_cfg_t         cfg_w [N_TMR];
    logic [CNT_W-1:0] cnt_w [N_TMR];
    logic [CNT_W-1:0] per_w [N_TMR];
    logic [CNT_W-1:0] wid_w [N_TMR];
    logic [N_TMR-1:0] evt_w, cfg_irq, cfg_run, cfg_pwm;
    logic [N_TMR*CNT_W-1:0] cnt_flat;
    logic [N_TMR-1:0] cfg_we, cnt_we, per_we, wid_we;
    logic             ctrl_we;

    assign ctrl_we = bus_we && (bus_addr == CTRL_ADDR);

    generate
        for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
            logic hit;
            assign hit       = bus_we && (bus_addr[ADDR_W-1:2] == SEL_W'(i));
            assign cfg_we[i] = hit && (bus_addr[1:0] == 2'd0);
            assign cnt_we[i] = hit && (bus_addr[1:0] == 2'd1);
            assign per_we[i] = hit && (bus_addr[1:0] == 2'd2);
            assign wid_we[i] = hit && (bus_addr[1:0] == 2'd3);

            gpt_channel #(.CNT_W(CNT_W), .SYNC_STGS(SYNC_STGS)) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (ctl_q.en[i]),
                .halt    (dbg_halt),
                .pin_i   (pin_in[i]),
                .cfg_we  (cfg_we[i]),
                .cnt_we  (cnt_we[i]),
                .per_we  (per_we[i]),
                .wid_we  (wid_we[i]),
                .wdata   (bus_wdata),
                .cfg_o   (cfg_w[i]),
                .cnt_o   (cnt_w[i]),
                .per_o   (per_w[i]),
                .wid_o   (wid_w[i]),
                .pin_o   (pin_out[i]),
                .pin_oe_o(pin_oe[i]),
                .evt_o   (evt_w[i])
            );

            assign cfg_irq[i] = cfg_w[i].irq_en;
            assign cfg_run[i] = cfg_w[i].run_on;
            assign cfg_pwm[i] = (cfg_w[i].mode == MODE_PWM);
            assign cnt_flat[i*CNT_W +: CNT_W] = cnt_w[i];
        end
    endgenerate

    always_comb begin
        ctl_d = ctl_q;
        if (ctrl_we) begin
            ctl_d.en  = bus_wdata[N_TMR-1:0];
            ctl_d.sts = ctl_q.sts & ~bus_wdata[STS_LSB +: N_TMR];
        end
        for (int i = 0; i < N_TMR; i++) begin
            if (evt_w[i]) begin
                ctl_d.sts[i] = 1'b1;
                if (!cfg_w[i].run_on) ctl_d.en[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata[N_TMR-1:0]         = ctl_q.en;
            bus_rdata[STS_LSB +: N_TMR]  = ctl_q.sts;
        end
        for (int i = 0; i < N_TMR; i++) begin
            if (bus_addr[ADDR_W-1:2] == SEL_W'(i)) begin
                unique case (bus_addr[1:0])
                    2'd0: bus_rdata = CNT_W'(cfg_w[i]);
                    2'd1: bus_rdata = cnt_w[i];
                    2'd2: bus_rdata = per_w[i];
                    default: bus_rdata = wid_w[i];
                endcase
            end
        end
    end

    assign irq = ctl_q.sts & cfg_irq;
endmodule

// File: rtl/gpt_bank_chk.sv
module gpt_bank_chk #(
    parameter int N_TMR   = 3,
    parameter int CNT_W   = 32,
    parameter int STS_LSB = 8,
    parameter int ADDR_W  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_we,
    input logic [CNT_W-1:0]       bus_wdata,
    input logic [N_TMR-1:0]       pin_oe,
    input logic [N_TMR-1:0]       irq,
    input logic [N_TMR-1:0]       en,
    input logic [N_TMR-1:0]       sts,
    input logic [N_TMR-1:0]       cfg_run,
    input logic [N_TMR-1:0]       cfg_pwm,
    input logic [N_TMR*CNT_W-1:0] cnt_flat
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(4*N_TMR);

    generate
        for (genvar i = 0; i < N_TMR; i++) begin : g_chk
            logic clr_hit, cnt_hit;
            assign clr_hit = bus_we && (bus_addr == CTRL_ADDR) && bus_wdata[STS_LSB+i];
            assign cnt_hit = bus_we && (bus_addr == ADDR_W'(4*i+1));

            // R9
            sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sts[i] && !clr_hit |=> sts[i]);

            // R9
            irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq[i] |-> sts[i]);

            // R4
            pin_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pin_oe[i] |-> (en[i] && cfg_pwm[i]));

            // R11
            idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !en[i] && !cnt_hit |=> $stable(cnt_flat[i*CNT_W +: CNT_W]));

            // R10
            one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(sts[i]) && !$past(cfg_run[i]) |-> !en[i]);
        end
    endgenerate
endmodule

bind gpt_bank gpt_bank_chk #(
    .N_TMR  (N_TMR),
    .CNT_W  (CNT_W),
    .STS_LSB(STS_LSB),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .en       (ctl_q.en),
    .sts      (ctl_q.sts),
    .cfg_run  (cfg_run),
    .cfg_pwm  (cfg_pwm),
    .cnt_flat (cnt_flat)
);

// File: tb/gpt_bank_test.sv
`timescale 1ns/100ps
module gpt_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_halt = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  pin_in = '0;
    logic [2:0]  pin_out, pin_oe, irq;

    int checks = 0;
    int errors = 0;

    localparam logic [3:0] CTRL = 4'd12;

    typedef struct {
        int          sel;   // 0 rdata, 1 pin_out, 2 pin_oe, 3 irq
        int          idx;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  go_ev, done_ev;

    always #2.5 clk = ~clk;

    gpt_bank uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .dbg_halt (dbg_halt),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .irq      (irq)
    );

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(go_ev);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.sel)
                    0:       act = bus_rdata;
                    1:       act = {31'd0, pin_out[it.idx]};
                    2:       act = {31'd0, pin_oe[it.idx]};
                    default: act = {31'd0, irq[it.idx]};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
                end
            end
            ->done_ev;
        end
    end

    function automatic logic [3:0] ra(int t, int off);
        return 4'(4*t + off);
    endfunction

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic push_chk(int sel, int idx, logic [31:0] exp, string tag);
        item_t it;
        it.sel = sel; it.idx = idx; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        ->go_ev;
        @(done_ev);
    endtask

    task automatic chk_rd(logic [3:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        push_chk(0, 0, exp, tag);
    endtask

    task automatic rd_val(logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic direct(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse(int t, int hi, int lo);
        @(negedge clk);
        pin_in[t] = 1'b1;
        repeat (hi) @(negedge clk);
        pin_in[t] = 1'b0;
        repeat (lo - 1) @(negedge clk);
    endtask

    // sample a pin for two periods, check periodicity and active count
    task automatic wave_chk(int t, int per, int act_hi, string tag);
        logic s [64];
        int   ones = 0;
        int   mism = 0;
        for (int k = 0; k < 2*per; k++) begin
            @(negedge clk);
            #1 s[k] = pin_out[t];
        end
        for (int k = 0; k < per; k++) begin
            ones += int'(s[k]);
            if (s[k] != s[k+per]) mism++;
        end
        direct({tag, " high clocks per period"}, ones, act_hi);
        direct({tag, " periodicity"}, mism, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_rd(CTRL, 32'h0, "R1 ctrl");
        chk_rd(ra(0,0), 32'h0, "R1 cfg0");
        chk_rd(ra(2,2), 32'h0, "R1 period2");
        push_chk(2, 1, 32'h0, "R1 pin_oe1");
        push_chk(1, 0, 32'h0, "R1 pin_out0");
        push_chk(3, 2, 32'h0, "R1 irq2");

        // R2 register map readback
        wr(ra(0,0), 32'h7F);
        chk_rd(ra(0,0), 32'h3F, "R2 cfg0 six bits");
        wr(ra(2,2), 32'h1234_5678);
        chk_rd(ra(2,2), 32'h1234_5678, "R2 period2");
        wr(ra(1,3), 32'hCAFE);
        chk_rd(ra(1,3), 32'hCAFE, "R2 width1");

        // R4 R5 pulse generation on timer 0
        wr(ra(0,0), 32'h29);    // run, irq_en, mode 01
        wr(ra(0,1), 32'h0);
        wr(ra(0,2), 32'd8);
        wr(ra(0,3), 32'd3);
        wr(CTRL, 32'h1);
        chk_rd(CTRL, 32'h1, "R3 enable0 only");
        push_chk(2, 0, 32'h1, "R4 pin_oe0 driven");
        wave_chk(0, 8, 3, "R4 pwm0");
        chk_rd(CTRL, 32'h101, "R5 event flag0");
        push_chk(3, 0, 32'h1, "R9 irq0 raised");

        // R9 write-1-clear, R11 hold when disabled
        wr(CTRL, 32'h100);
        chk_rd(CTRL, 32'h0, "R9 flag0 cleared");
        push_chk(3, 0, 32'h0, "R9 irq0 low");
        push_chk(2, 0, 32'h0, "R4 pin_oe0 released");
        rd_val(ra(0,1), v);
        repeat (4) @(negedge clk);
        chk_rd(ra(0,1), v, "R11 count0 held");
        chk_rd(ra(0,2), 32'd8, "R11 period0 kept");

        // R10 one-shot on timer 1
        wr(ra(1,0), 32'h09);    // irq_en, mode 01, run_on=0
        wr(ra(1,1), 32'h0);
        wr(ra(1,2), 32'd5);
        wr(ra(1,3), 32'd2);
        wr(CTRL, 32'h2);
        repeat (12) @(negedge clk);
        chk_rd(CTRL, 32'h200, "R10 one-shot disables");
        chk_rd(ra(1,1), 32'h0, "R5 count1 reloaded");
        wr(CTRL, 32'h200);
        wr(ra(1,0), 32'h29);
        wr(CTRL, 32'h2);
        repeat (12) @(negedge clk);
        chk_rd(CTRL, 32'h202, "R10 free-run stays enabled");

        // R8 inverted waveform and idle level
        wr(ra(1,0), 32'h2D);
        wave_chk(1, 5, 3, "R8 inverted pwm1");
        wr(CTRL, 32'h200);
        push_chk(1, 1, 32'h1, "R8 idle level inverted");

        // R12 debug halt
        wr(ra(1,0), 32'h29);
        wr(ra(1,1), 32'h0);
        wr(ra(1,2), 32'd1000);
        wr(ra(1,3), 32'd10);
        wr(CTRL, 32'h2);
        dbg_halt = 1'b1;
        rd_val(ra(1,1), v);
        repeat (4) @(negedge clk);
        chk_rd(ra(1,1), v, "R12 halted count held");
        wr(ra(1,0), 32'h39);
        rd_val(ra(1,1), v);
        repeat (4) @(negedge clk);
        chk_rd(ra(1,1), v + 32'd5, "R12 emu_run keeps counting");
        dbg_halt = 1'b0;
        wr(CTRL, 32'h0);

        // R6 capture on timer 2
        wr(ra(2,0), 32'h22);    // run, mode 10, no irq
        wr(ra(2,2), 32'h0);
        wr(ra(2,3), 32'h0);
        wr(CTRL, 32'h4);
        push_chk(2, 2, 32'h0, "R6 pin2 is input");
        pulse(2, 4, 6);
        pulse(2, 4, 6);
        pulse(2, 4, 6);
        repeat (6) @(negedge clk);
        chk_rd(ra(2,3), 32'd4, "R6 captured width");
        chk_rd(ra(2,2), 32'd10, "R6 captured period");
        chk_rd(CTRL, 32'h404, "R6 capture flag");
        push_chk(3, 2, 32'h0, "R9 irq2 masked");

        // R7 edge count on timer 0
        wr(ra(0,0), 32'h2B);
        wr(ra(0,1), 32'h0);
        wr(ra(0,2), 32'd3);
        wr(CTRL, 32'h5);
        push_chk(2, 0, 32'h0, "R7 pin0 is input");
        pulse(0, 2, 2);
        pulse(0, 2, 2);
        repeat (4) @(negedge clk);
        chk_rd(ra(0,1), 32'd2, "R7 two edges counted");
        chk_rd(CTRL, 32'h405, "R7 no flag before limit");
        pulse(0, 2, 2);
        repeat (4) @(negedge clk);
        chk_rd(ra(0,1), 32'd0, "R7 count reset at limit");
        chk_rd(CTRL, 32'h505, "R7 flag at limit");
        push_chk(3, 0, 32'h1, "R7 irq0 raised");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule